// File: doc/BRIEF.md
# Timer channel status flag register

This block is the 8-bit status register of one channel in a multi-channel 16-bit timer. It takes single-cycle event pulses from the channel's counter and compare/capture logic and keeps each one as a sticky flag. Software reads these flags over a simple register bus. The register also reports the counter's current count direction. Two bits are reserved.

Software clears a flag with a two-step handshake. It first reads the register while the flag is 1. It then writes 0 to that bit. A write with no such prior read has no effect on any flag.

The parameter `CHAN` sets the channel index. It decides which bits are reserved and what those bits read back.

Top module: `tmr_stat_reg`

## Requirements
- R1: After reset the register reads 0xC0 on every channel: bits 7 and 6 read 1, and bits 5..0 read 0.
- R2: Bit 6 always reads 1. On channel 0, bit 7 always reads 1, whatever the direction input or the written data.
- R3: On channels 1 to 4, bit 7 shows the direction input (1 = counting up, 0 = counting down), registered one cycle later.
- R4: Bit 5 is the underflow flag. On channels 1 and 2 an underflow pulse sets it. On channels 0, 3 and 4 it always reads 0, even when an underflow pulse arrives.
- R5: An overflow pulse sets bit 4. Compare/capture pulses for general registers A, B, C and D set bits 0, 1, 2 and 3 in that order. A flag reads 1 from the cycle after its pulse.
- R6: A write of 0 to a flag bit clears that flag on the next cycle, provided the last read before that write returned 1 for the bit.
- R7: A write of 0 to a flag that was not read as 1 beforehand leaves the flag set. Writing 1 never changes a flag.
- R8: Each write consumes the arming from the preceding read. A second write needs a new read before it can clear anything.
- R9: If a flag's set pulse and a valid clear of that flag fall in the same cycle, the flag stays 1. Other flags cleared by the same write still clear.
- R10: A read that returned 0 for a flag does not arm that flag. The flag may set after the read; a following write of 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe. It captures which flags read as 1. |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data. A 0 clears an armed flag. |
| rdata | output | 8 | Current register value |
| dir_up | input | 1 | Counter direction, 1 = up |
| evt_udf | input | 1 | Underflow pulse (counter went from 0x0000 to 0xFFFF) |
| evt_ovf | input | 1 | Overflow pulse (counter went from 0xFFFF to 0x0000) |
| evt_cmp | input | 4 | Compare/capture pulses. Index 0..3 corresponds to general registers A..D. |

## Verification
An event pulse that sets a flag can arrive in the same cycle as a write that clears the same flag. The bench provokes this by arming the overflow and B flags with a read. It then writes 0 to the register while the B pulse is high.

The expected result is that B still reads 1 and overflow reads 0. This shows that the set takes priority over the clear, and that the priority applies to each bit separately. The same scenario runs on all five channel indices at once.

// File: rtl/tmr_stat_reg.sv
module tmr_stat_reg #(
  parameter int CHAN = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       dir_up,
  input  logic       evt_udf,
  input  logic       evt_ovf,
  input  logic [3:0] evt_cmp
);
  localparam bit HAS_UDF = (CHAN == 1) || (CHAN == 2);
  localparam bit HAS_DIR = (CHAN != 0);

  logic       dir_q;
  logic [5:0] flg_q;
  logic [5:0] arm_q;
  logic [5:0] set_v;
  logic [5:0] clr_v;

  assign set_v = {evt_udf & HAS_UDF, evt_ovf, evt_cmp};
  assign clr_v = wr_en ? (arm_q & ~wdata[5:0]) : 6'b0;
  assign rdata = {HAS_DIR ? dir_q : 1'b1, 1'b1, flg_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= 1'b1;
      flg_q <= '0;
      arm_q <= '0;
    end else begin
      dir_q <= dir_up;
      flg_q <= (flg_q & ~clr_v) | set_v;
      if (rd_en)
        arm_q <= flg_q;
      else if (wr_en)
        arm_q <= '0;
    end
  end
endmodule

module tmr_stat_reg_chk #(
  parameter int CHAN = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       dir_up,
  input logic       evt_udf,
  input logic       evt_ovf,
  input logic [3:0] evt_cmp,
  input logic [5:0] arm_q
);
  assert_rst_val_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rdata == 8'hC0);
  assert_rsvd6_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6]);
  assert_ch0_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (CHAN == 0) |-> rdata[7]);
  assert_dir_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (CHAN != 0) |=> rdata[7] == $past(dir_up));
  assert_udf_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (CHAN == 0 || CHAN == 3 || CHAN == 4) |-> !rdata[5]);
  assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> rdata[4]);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && arm_q[0] && !wdata[0] && !evt_cmp[0]) |=> !rdata[0]);
  assert_write_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[4] && rdata[4]) |=> rdata[4]);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[1] && evt_cmp[1]) |=> rdata[1]);
  assert_udf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((CHAN == 1 || CHAN == 2) && evt_udf) |=> rdata[5]);
endmodule

bind tmr_stat_reg tmr_stat_reg_chk #(.CHAN(CHAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .dir_up(dir_up), .evt_udf(evt_udf), .evt_ovf(evt_ovf), .evt_cmp(evt_cmp),
  .arm_q(arm_q)
);

// File: tb/tmr_stat_reg_bench.sv
module tmr_stat_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       dir_up = 1'b1;
  logic       evt_udf = 1'b0;
  logic       evt_ovf = 1'b0;
  logic [3:0] evt_cmp = 4'h0;
  logic [7:0] rd [5];

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  for (genvar c = 0; c < 5; c++) begin : g_ch
    if (c == 1) begin : g_main
      tmr_stat_reg #(.CHAN(c)) u_tmr_stat_reg (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .rdata(rd[c]), .dir_up(dir_up), .evt_udf(evt_udf), .evt_ovf(evt_ovf),
        .evt_cmp(evt_cmp));
    end else begin : g_other
      tmr_stat_reg #(.CHAN(c)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
        .rdata(rd[c]), .dir_up(dir_up), .evt_udf(evt_udf), .evt_ovf(evt_ovf),
        .evt_cmp(evt_cmp));
    end
  end

  function automatic logic [7:0] expv(int c, bit d, logic [5:0] lo);
    return {(c == 0) ? 1'b1 : d, 1'b1, (c == 1 || c == 2) ? lo[5] : 1'b0, lo[4:0]};
  endfunction

  task automatic chk_all(string req, bit d, logic [5:0] lo);
    for (int c = 0; c < 5; c++) begin
      checks++;
      if (rd[c] !== expv(c, d, lo)) begin
        errors++;
        $display("FAIL %s ch%0d: actual=%h expected=%h", req, c, rd[c], expv(c, d, lo));
      end
    end
  endtask

  task automatic cyc(bit r, bit w, logic [7:0] wd, bit u, bit o, logic [3:0] cm);
    @(negedge clk);
    rd_en = r; wr_en = w; wdata = wd; evt_udf = u; evt_ovf = o; evt_cmp = cm;
    @(negedge clk);
    rd_en = 0; wr_en = 0; wdata = 8'h00; evt_udf = 0; evt_ovf = 0; evt_cmp = 4'h0;
  endtask

  task automatic t_reset;
    chk_all("R1 reset", 1'b1, 6'b000000);
  endtask

  task automatic t_dir;
    @(negedge clk); dir_up = 1'b0;
    @(negedge clk);
    chk_all("R3 dir down / R2 ch0 bit7", 1'b0, 6'b000000);
    cyc(0, 1, 8'h00, 0, 0, 4'h0);
    chk_all("R2 write to bit7/6 ignored", 1'b0, 6'b000000);
    @(negedge clk); dir_up = 1'b1;
    @(negedge clk);
    chk_all("R3 dir up", 1'b1, 6'b000000);
  endtask

  task automatic t_set;
    cyc(0, 0, 8'h00, 1, 1, 4'b1010);
    chk_all("R4 R5 set udf/ovf/D/B", 1'b1, 6'b111010);
  endtask

  task automatic t_noread;
    cyc(0, 1, 8'h00, 0, 0, 4'h0);
    chk_all("R7 write 0 without read", 1'b1, 6'b111010);
  endtask

  task automatic t_consume;
    cyc(1, 0, 8'h00, 0, 0, 4'h0);
    cyc(0, 1, 8'hFF, 0, 0, 4'h0);
    chk_all("R7 write 1 keeps flags", 1'b1, 6'b111010);
    cyc(0, 1, 8'h00, 0, 0, 4'h0);
    chk_all("R8 arming consumed", 1'b1, 6'b111010);
  endtask

  task automatic t_clear;
    cyc(1, 0, 8'h00, 0, 0, 4'h0);
    cyc(0, 1, 8'hF7, 0, 0, 4'h0);
    chk_all("R6 clear D only", 1'b1, 6'b110010);
    cyc(1, 0, 8'h00, 0, 0, 4'h0);
    cyc(0, 1, 8'h00, 0, 0, 4'h0);
    chk_all("R6 clear all", 1'b1, 6'b000000);
  endtask

  task automatic t_stale;
    cyc(1, 0, 8'h00, 0, 0, 4'h0);
    cyc(0, 0, 8'h00, 0, 0, 4'b0001);
    chk_all("R5 set A", 1'b1, 6'b000001);
    cyc(0, 1, 8'h00, 0, 0, 4'h0);
    chk_all("R10 read of 0 does not arm", 1'b1, 6'b000001);
    cyc(1, 0, 8'h00, 0, 0, 4'h0);
    cyc(0, 1, 8'hFE, 0, 0, 4'h0);
    chk_all("R6 clear A", 1'b1, 6'b000000);
  endtask

  task automatic t_collide;
    cyc(0, 0, 8'h00, 0, 1, 4'b0010);
    cyc(1, 0, 8'h00, 0, 0, 4'h0);
    cyc(0, 1, 8'h00, 0, 0, 4'b0010);
    chk_all("R9 set wins over clear", 1'b1, 6'b000010);
    cyc(1, 0, 8'h00, 0, 0, 4'h0);
    cyc(0, 1, 8'h00, 0, 0, 4'h0);
    chk_all("R9 later clear", 1'b1, 6'b000000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir();
    t_set();
    t_noread();
    t_consume();
    t_clear();
    t_stale();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule